// File: doc/BRIEF.md
# Five-Stage In-Order Integer Pipeline

This block is a small 32-bit RISC-V integer core built as five stages: fetch, decode, execute, memory access and write-back. It runs a reduced instruction set: `add`, `sub`, `addi` (which also covers the load-immediate alias `li` and the canonical `nop`), `slli`, word `lw`, word `sw` and `bne`. The block contains the program counter, the pipeline registers, the next-PC selector, one shared ALU, a 32-entry register file, a word-wide instruction memory and a word-wide data memory. A testbench fills the instruction memory through a write port while reset is held.

The pipeline has no operand forwarding and no interlock. Software must keep dependent instructions apart. The register file passes a value that is being written straight through to a decode-stage read in the same cycle, so a consumer must be at least three instructions after its producer. This also applies after a load. Branches are resolved in execute. The shared ALU forms the target from the branch's own PC, and a taken branch turns the two younger instructions into bubbles. A combinational debug port reads any architectural register.

Top module: `rvp_core`

## Requirements
- R1: While `rst_ni` is low, and straight after it rises, every register reads zero through the debug port. The PC starts at 0, and every pipeline stage holds a bubble that writes nothing.
- R2: Instructions use the standard RV32I encodings. `add` and `sub` use opcode 0110011 with funct3 000 and funct7 0000000 / 0100000. `addi` and `slli` use opcode 0010011 with funct3 000 / 001, and `slli` needs funct7 0000000. Each writes its 32-bit result to rd in write-back, with wrap-around arithmetic and shifts of up to 31 places. Any other encoding, including all zeros, has no effect.
- R3: Register x0 always reads zero, even after an instruction names it as the destination.
- R4: When no taken branch is in execute, the next PC is the current PC plus 4.
- R5: `bne` (opcode 1100011, funct3 001) is taken when its two source registers differ. Its target is its own PC plus the sign-extended B-type offset, computed by the ALU in execute. The target is fetched in the following cycle, so a loop costs two cycles more than its instruction count.
- R6: A taken branch squashes the two instructions fetched after it. They write neither a register nor memory.
- R7: A `bne` whose operands are equal falls through to the next sequential instruction.
- R8: `sw` (opcode 0100011, funct3 010) writes rs2 to the data word at rs1 plus offset during the memory stage. `lw` (opcode 0000011, funct3 010) reads that word and writes it to rd. A store can be read by a load issued directly after it.
- R9: A register written in write-back is seen by an instruction that reads it in decode in the same cycle. No other result is forwarded.
- R10: `dbg_data_o` shows the register addressed by `dbg_addr_i` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| imem_we_i | input | 1 | Instruction memory write strobe |
| imem_addr_i | input | IA_W | Instruction memory word index |
| imem_wdata_i | input | 32 | Instruction word to write |
| dbg_addr_i | input | 5 | Register index for the debug read |
| dbg_data_o | output | XLEN | Contents of the addressed register |

## Verification
Three programs are run.

The first is a store-load-loop sequence whose loop branch is always taken. It shows that the stored word comes back through the load, that the doubling register moves once every seven cycles (five instructions plus two squashed slots), and that the two instructions after the branch never write.

The second is a countdown loop that is taken twice and then falls through. It separates the taken path from the not-taken path, and it shows that the loop body ran the right number of times.

The third is a straight-line block. It drives negative operands, a subtraction that wraps, shifts by 4 and by 31, an attempted write to x0, and a load placed directly after a store. These cases test the ALU edge cases, the protection of x0 and the timing of data memory.

// File: rtl/rvp_pkg.sv
package rvp_pkg;
  localparam logic [6:0] OPC_OP     = 7'b0110011;
  localparam logic [6:0] OPC_OP_IMM = 7'b0010011;
  localparam logic [6:0] OPC_LOAD   = 7'b0000011;
  localparam logic [6:0] OPC_STORE  = 7'b0100011;
  localparam logic [6:0] OPC_BRANCH = 7'b1100011;

  typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_SLL} alu_op_e;

  typedef struct packed {
    logic    reg_we;
    logic    mem_we;
    logic    mem_re;
    logic    a_pc;
    logic    b_imm;
    logic    branch;
    alu_op_e alu_op;
  } ctrl_t;
endpackage

// File: rtl/rvp_decode.sv
module rvp_decode
  import rvp_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [31:0]     instr_i,
  output ctrl_t           ctrl_o,
  output logic [4:0]      rd_o,
  output logic [4:0]      rs1_o,
  output logic [4:0]      rs2_o,
  output logic [XLEN-1:0] imm_o
);
  logic [6:0] opc, f7;
  logic [2:0] f3;

  assign opc   = instr_i[6:0];
  assign f3    = instr_i[14:12];
  assign f7    = instr_i[31:25];
  assign rd_o  = instr_i[11:7];
  assign rs1_o = instr_i[19:15];
  assign rs2_o = instr_i[24:20];

  always_comb begin
    ctrl_o = '0;
    ctrl_o.alu_op = ALU_ADD;
    imm_o = '0;
    case (opc)
      OPC_OP: begin
        if (f3 == 3'b000 && f7 == 7'b0000000) begin
          ctrl_o.reg_we = 1'b1;
        end else if (f3 == 3'b000 && f7 == 7'b0100000) begin
          ctrl_o.reg_we = 1'b1;
          ctrl_o.alu_op = ALU_SUB;
        end
      end
      OPC_OP_IMM: begin
        if (f3 == 3'b000) begin
          ctrl_o.reg_we = 1'b1;
          ctrl_o.b_imm  = 1'b1;
          imm_o = {{(XLEN-12){instr_i[31]}}, instr_i[31:20]};
        end else if (f3 == 3'b001 && f7 == 7'b0000000) begin
          ctrl_o.reg_we = 1'b1;
          ctrl_o.b_imm  = 1'b1;
          ctrl_o.alu_op = ALU_SLL;
          imm_o = {{(XLEN-5){1'b0}}, instr_i[24:20]};
        end
      end
      OPC_LOAD: begin
        if (f3 == 3'b010) begin
          ctrl_o.reg_we = 1'b1;
          ctrl_o.mem_re = 1'b1;
          ctrl_o.b_imm  = 1'b1;
          imm_o = {{(XLEN-12){instr_i[31]}}, instr_i[31:20]};
        end
      end
      OPC_STORE: begin
        if (f3 == 3'b010) begin
          ctrl_o.mem_we = 1'b1;
          ctrl_o.b_imm  = 1'b1;
          imm_o = {{(XLEN-12){instr_i[31]}}, instr_i[31:25], instr_i[11:7]};
        end
      end
      OPC_BRANCH: begin
        if (f3 == 3'b001) begin
          ctrl_o.branch = 1'b1;
          ctrl_o.a_pc   = 1'b1;
          ctrl_o.b_imm  = 1'b1;
          imm_o = {{(XLEN-13){instr_i[31]}}, instr_i[31], instr_i[7],
                   instr_i[30:25], instr_i[11:8], 1'b0};
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/rvp_alu.sv
module rvp_alu
  import rvp_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  alu_op_e         op_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic [XLEN-1:0] res_o
);
  localparam int SH_W = $clog2(XLEN);

  logic [XLEN-1:0] unused_b;
  assign unused_b = b_i;

  always_comb begin
    case (op_i)
      ALU_SUB: res_o = a_i - b_i;
      ALU_SLL: res_o = a_i << b_i[SH_W-1:0];
      default: res_o = a_i + b_i;
    endcase
  end
endmodule

// File: rtl/rvp_regfile.sv
module rvp_regfile #(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [AW-1:0]   ra1_i,
  input  logic [AW-1:0]   ra2_i,
  output logic [XLEN-1:0] rd1_o,
  output logic [XLEN-1:0] rd2_o,
  input  logic [AW-1:0]   dbg_addr_i,
  output logic [XLEN-1:0] dbg_data_o,
  input  logic            we_i,
  input  logic [AW-1:0]   wa_i,
  input  logic [XLEN-1:0] wd_i
);
  logic [XLEN-1:0] regs_q [NREG];
  logic            wr_en;

  assign wr_en = we_i && (wa_i != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else if (wr_en) begin
      regs_q[wa_i] <= wd_i;
    end
  end

  // write-through so decode sees the value being retired this cycle
  assign rd1_o      = (wr_en && wa_i == ra1_i) ? wd_i : regs_q[ra1_i];
  assign rd2_o      = (wr_en && wa_i == ra2_i) ? wd_i : regs_q[ra2_i];
  assign dbg_data_o = regs_q[dbg_addr_i];

  AST_RF_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |=> regs_q[$past(wa_i)] == $past(wd_i)); // R9
  AST_X0_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_addr_i == '0) |-> (dbg_data_o == '0)); // R3
endmodule

// File: rtl/rvp_core.sv
module rvp_core
  import rvp_pkg::*;
#(
  parameter int XLEN        = 32,
  parameter int IMEM_WORDS  = 64,
  parameter int DMEM_WORDS  = 64,
  localparam int IA_W       = $clog2(IMEM_WORDS),
  localparam int DA_W       = $clog2(DMEM_WORDS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            imem_we_i,
  input  logic [IA_W-1:0] imem_addr_i,
  input  logic [31:0]     imem_wdata_i,
  input  logic [4:0]      dbg_addr_i,
  output logic [XLEN-1:0] dbg_data_o
);
  typedef struct packed {
    logic            valid;
    logic [XLEN-1:0] pc;
    logic [31:0]     instr;
  } if_id_t;

  typedef struct packed {
    logic            valid;
    ctrl_t           ctrl;
    logic [XLEN-1:0] pc;
    logic [XLEN-1:0] a_val;
    logic [XLEN-1:0] b_val;
    logic [XLEN-1:0] imm;
    logic [4:0]      rd;
  } id_ex_t;

  typedef struct packed {
    logic            valid;
    logic            reg_we;
    logic            mem_we;
    logic            mem_re;
    logic [4:0]      rd;
    logic [XLEN-1:0] res;
    logic [XLEN-1:0] st_data;
  } ex_mem_t;

  typedef struct packed {
    logic            valid;
    logic            reg_we;
    logic [4:0]      rd;
    logic [XLEN-1:0] data;
  } mem_wb_t;

  logic [31:0]     imem_q [IMEM_WORDS];
  logic [XLEN-1:0] dmem_q [DMEM_WORDS];

  logic [XLEN-1:0] pc_q, pc_d;
  if_id_t  if_id_q;
  id_ex_t  id_ex_q;
  ex_mem_t ex_mem_q;
  mem_wb_t mem_wb_q;

  // ---------------- fetch ----------------
  logic [31:0] if_instr;
  logic        ex_take;
  logic [XLEN-1:0] alu_res;

  always_ff @(posedge clk_i) begin
    if (imem_we_i) imem_q[imem_addr_i] <= imem_wdata_i;
  end

  assign if_instr = imem_q[pc_q[IA_W+1:2]];
  assign pc_d     = ex_take ? alu_res : pc_q + XLEN'(4);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q    <= '0;
      if_id_q <= '0;
    end else begin
      pc_q <= pc_d;
      if (ex_take) if_id_q <= '0;
      else         if_id_q <= '{valid: 1'b1, pc: pc_q, instr: if_instr};
    end
  end

  // ---------------- decode ----------------
  ctrl_t           id_ctrl;
  logic [4:0]      id_rd, id_rs1, id_rs2;
  logic [XLEN-1:0] id_imm, id_rv1, id_rv2;

  rvp_decode #(.XLEN(XLEN)) u_dec (
    .instr_i (if_id_q.instr),
    .ctrl_o  (id_ctrl),
    .rd_o    (id_rd),
    .rs1_o   (id_rs1),
    .rs2_o   (id_rs2),
    .imm_o   (id_imm)
  );

  rvp_regfile #(.XLEN(XLEN), .NREG(32)) u_rf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ra1_i      (id_rs1),
    .ra2_i      (id_rs2),
    .rd1_o      (id_rv1),
    .rd2_o      (id_rv2),
    .dbg_addr_i (dbg_addr_i),
    .dbg_data_o (dbg_data_o),
    .we_i       (mem_wb_q.valid && mem_wb_q.reg_we),
    .wa_i       (mem_wb_q.rd),
    .wd_i       (mem_wb_q.data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      id_ex_q <= '0;
    end else if (ex_take || !if_id_q.valid) begin
      id_ex_q <= '0;
    end else begin
      id_ex_q <= '{valid: 1'b1, ctrl: id_ctrl, pc: if_id_q.pc, a_val: id_rv1,
                   b_val: id_rv2, imm: id_imm, rd: id_rd};
    end
  end

  // ---------------- execute ----------------
  logic [XLEN-1:0] op_a, op_b;

  assign op_a = id_ex_q.ctrl.a_pc  ? id_ex_q.pc  : id_ex_q.a_val;
  assign op_b = id_ex_q.ctrl.b_imm ? id_ex_q.imm : id_ex_q.b_val;

  rvp_alu #(.XLEN(XLEN)) u_alu (
    .op_i  (id_ex_q.ctrl.alu_op),
    .a_i   (op_a),
    .b_i   (op_b),
    .res_o (alu_res)
  );

  assign ex_take = id_ex_q.valid && id_ex_q.ctrl.branch &&
                   (id_ex_q.a_val != id_ex_q.b_val);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ex_mem_q <= '0;
    end else begin
      ex_mem_q <= '{valid: id_ex_q.valid, reg_we: id_ex_q.ctrl.reg_we,
                    mem_we: id_ex_q.ctrl.mem_we, mem_re: id_ex_q.ctrl.mem_re,
                    rd: id_ex_q.rd, res: alu_res, st_data: id_ex_q.b_val};
    end
  end

  // ---------------- memory ----------------
  logic [DA_W-1:0] dm_idx;
  logic            dm_we;

  assign dm_idx = ex_mem_q.res[DA_W+1:2];
  assign dm_we  = ex_mem_q.valid && ex_mem_q.mem_we;

  always_ff @(posedge clk_i) begin
    if (dm_we) dmem_q[dm_idx] <= ex_mem_q.st_data;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_wb_q <= '0;
    end else begin
      mem_wb_q <= '{valid: ex_mem_q.valid, reg_we: ex_mem_q.reg_we, rd: ex_mem_q.rd,
                    data: ex_mem_q.mem_re ? dmem_q[dm_idx] : ex_mem_q.res};
    end
  end

  logic unused_bits;
  assign unused_bits = ^{pc_q[1:0], pc_q[XLEN-1:IA_W+2],
                         ex_mem_q.res[1:0], ex_mem_q.res[XLEN-1:DA_W+2]};

  AST_PC_SEQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ex_take |=> pc_q == $past(pc_q) + XLEN'(4)); // R4
  AST_PC_BRANCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ex_take |=> pc_q == $past(id_ex_q.pc) + $past(id_ex_q.imm)); // R5
  AST_SQUASH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ex_take |=> !if_id_q.valid && !id_ex_q.valid); // R6
  AST_DMEM_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dm_we |=> dmem_q[$past(dm_idx)] == $past(ex_mem_q.st_data)); // R8
endmodule

// File: tb/rvp_core_tb.sv
`timescale 1ns/1ps
module rvp_core_tb_top;
  localparam int IA_W = 6;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            imem_we = 1'b0;
  logic [IA_W-1:0] imem_addr = '0;
  logic [31:0]     imem_wdata = '0;
  logic [4:0]      dbg_addr = '0;
  logic [31:0]     dbg_data;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  logic [31:0] prog [64];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rvp_core dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .imem_we_i    (imem_we),
    .imem_addr_i  (imem_addr),
    .imem_wdata_i (imem_wdata),
    .dbg_addr_i   (dbg_addr),
    .dbg_data_o   (dbg_data)
  );

  // encoders
  function automatic logic [31:0] addi(int rd, int rs1, int imm);
    logic [11:0] i = imm[11:0];
    return {i, rs1[4:0], 3'b000, rd[4:0], 7'b0010011};
  endfunction
  function automatic logic [31:0] slli(int rd, int rs1, int sh);
    return {7'b0, sh[4:0], rs1[4:0], 3'b001, rd[4:0], 7'b0010011};
  endfunction
  function automatic logic [31:0] radd(int rd, int rs1, int rs2);
    return {7'b0000000, rs2[4:0], rs1[4:0], 3'b000, rd[4:0], 7'b0110011};
  endfunction
  function automatic logic [31:0] rsub(int rd, int rs1, int rs2);
    return {7'b0100000, rs2[4:0], rs1[4:0], 3'b000, rd[4:0], 7'b0110011};
  endfunction
  function automatic logic [31:0] lw(int rd, int rs1, int imm);
    logic [11:0] i = imm[11:0];
    return {i, rs1[4:0], 3'b010, rd[4:0], 7'b0000011};
  endfunction
  function automatic logic [31:0] sw(int rs2, int rs1, int imm);
    logic [11:0] i = imm[11:0];
    return {i[11:5], rs2[4:0], rs1[4:0], 3'b010, i[4:0], 7'b0100011};
  endfunction
  function automatic logic [31:0] bne(int rs1, int rs2, int off);
    logic [12:0] b = off[12:0];
    return {b[12], b[10:5], rs2[4:0], rs1[4:0], 3'b001, b[4:1], b[11], 7'b1100011};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd_reg(int idx, output logic [31:0] val);
    @(negedge clk);
    dbg_addr = idx[4:0];
    #1 val = dbg_data;
  endtask

  // hold reset, load prog[0:n-1], zero the rest, release
  task automatic boot(int n);
    rst_n = 1'b0;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      imem_we = 1'b1;
      imem_addr = i[IA_W-1:0];
      imem_wdata = (i < n) ? prog[i] : 32'h0;
    end
    @(negedge clk);
    imem_we = 1'b0;
    rst_n = 1'b1;
  endtask

  task automatic test_reset();
    logic [31:0] v;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rd_reg(13, v); chk("R1 reg a3 in reset", v, 32'h0);
    rd_reg(0, v);  chk("R1 reg x0 in reset", v, 32'h0);
  endtask

  task automatic test_demo_loop();
    logic [31:0] v, last;
    logic [31:0] seen [4];
    int          when [4];
    int          k = 0;
    prog[0]  = addi(10, 0, 5);
    prog[1]  = addi(11, 0, 7);
    prog[2]  = addi(12, 0, 3);
    prog[3]  = addi(0, 0, 0);
    prog[4]  = sw(10, 0, 'hBC);
    prog[5]  = lw(13, 0, 'hBC);
    prog[6]  = radd(14, 10, 11);
    prog[7]  = rsub(15, 11, 12);
    prog[8]  = radd(14, 13, 13);
    prog[9]  = slli(13, 13, 1);
    prog[10] = bne(15, 0, -16);
    prog[11] = addi(16, 0, 'h55);
    prog[12] = addi(17, 0, 'h66);
    boot(13);
    rd_reg(13, v); chk("R1 a3 after reset", v, 32'h0);
    last = 0;
    for (int c = 0; c < 300 && k < 4; c++) begin
      rd_reg(13, v);
      if (v !== last) begin
        seen[k] = v; when[k] = cyc; k++; last = v;
      end
    end
    chk("R8 a3 loaded from stored word", seen[0], 32'd5);
    chk("R2 a3 doubled once", seen[1], 32'd10);
    chk("R5 a3 doubled twice", seen[2], 32'd20);
    chk("R5 a3 doubled thrice", seen[3], 32'd40);
    chk("R5 loop period 7 cycles", 32'(when[3] - when[2]), 32'd7);
    chk("R6 loop period 7 cycles", 32'(when[2] - when[1]), 32'd7);
    rd_reg(10, v); chk("R10 a0", v, 32'd5);
    rd_reg(11, v); chk("R9 a1", v, 32'd7);
    rd_reg(12, v); chk("R9 a2", v, 32'd3);
    rd_reg(15, v); chk("R2 a5 sub", v, 32'd4);
    rd_reg(16, v); chk("R6 squashed a6", v, 32'd0);
    rd_reg(17, v); chk("R6 squashed a7", v, 32'd0);
  endtask

  task automatic test_countdown();
    logic [31:0] v;
    prog[0]  = addi(5, 0, 3);
    prog[1]  = addi(7, 0, 1);
    prog[2]  = addi(0, 0, 0);
    prog[3]  = addi(0, 0, 0);
    prog[4]  = addi(5, 5, -1);
    prog[5]  = addi(6, 6, 1);
    prog[6]  = addi(0, 0, 0);
    prog[7]  = addi(0, 0, 0);
    prog[8]  = bne(5, 0, -16);
    prog[9]  = addi(28, 0, 9);
    prog[10] = bne(7, 0, 0);
    prog[11] = addi(29, 0, 1);
    boot(12);
    repeat (80) @(negedge clk);
    rd_reg(5, v);  chk("R5 countdown t0", v, 32'd0);
    rd_reg(6, v);  chk("R5 loop body count", v, 32'd3);
    rd_reg(28, v); chk("R7 fall-through write", v, 32'd9);
    rd_reg(29, v); chk("R6 halt squashes next", v, 32'd0);
  endtask

  task automatic test_arith();
    logic [31:0] v;
    prog[0]  = addi(0, 0, 5);
    prog[1]  = addi(8, 0, -6);
    prog[2]  = addi(9, 0, 11);
    prog[3]  = addi(18, 0, 1);
    prog[4]  = addi(0, 0, 0);
    prog[5]  = radd(10, 8, 9);
    prog[6]  = rsub(11, 8, 9);
    prog[7]  = slli(12, 9, 4);
    prog[8]  = slli(13, 9, 31);
    prog[9]  = sw(9, 0, 'h3C);
    prog[10] = lw(14, 0, 'h3C);
    prog[11] = bne(18, 0, 0);
    boot(12);
    repeat (40) @(negedge clk);
    rd_reg(0, v);  chk("R3 x0 after write attempt", v, 32'h0);
    rd_reg(8, v);  chk("R2 addi negative", v, 32'hFFFF_FFFA);
    rd_reg(10, v); chk("R2 add", v, 32'd5);
    rd_reg(11, v); chk("R2 sub wrap", v, 32'hFFFF_FFEF);
    rd_reg(12, v); chk("R2 slli 4", v, 32'd176);
    rd_reg(13, v); chk("R2 slli 31", v, 32'h8000_0000);
    rd_reg(14, v); chk("R8 load right after store", v, 32'd11);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: all requirements, actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    test_reset();
    test_demo_loop();
    test_countdown();
    test_arith();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule